// File: doc/BRIEF.md
# Keyed Watchdog Enable Controller

This block is a watchdog that guards a system against a hung processor. Software first puts the block into watchdog mode through a global control register, sets a 64-bit timeout period, and then arms the watchdog with two keyed writes to the watchdog control register. Once armed, a 64-bit up-counter advances one step per clock. If software does not service the watchdog before the counter reaches the period, the block raises a reset request toward the system reset logic.

Servicing repeats the same two keys while the watchdog is armed, which clears the counter. Any write to the watchdog control register with a key other than the two valid keys forces the reset request at once. The armed state and the reset request can only be left through the block's own reset. Register access uses a simple single-cycle write strobe with a combinational read port.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every register reads zero (count halves 0x10/0x14, period halves 0x18/0x1C, global control 0x24, watchdog control 0x28) and `wd_rst_req` is low.
- R2: With the global control set to watchdog mode, a write to 0x28 with key 0xA5C6 in bits 31:16 and bit 14 set, followed by a write with key 0xDA7E and bit 14 set, arms the watchdog; 0x28 then reads 0x0000_4000 and the counter starts from its held value.
- R3: After the first key has been accepted, any other write to 0x28 returns the sequence to its start, so a later 0xDA7E write alone does not arm.
- R4: Arming writes have no effect unless global control bits 3:2 equal 2 and bits 1:0 both equal 1.
- R5: Once armed, bit 14 of 0x28 stays set whatever is written, and writes to the count, period and global control registers are ignored.
- R6: While armed and no request is pending, the count rises by one each clock; on the clock where the count equals the period, `wd_rst_req` is raised and the count then stops.
- R7: With a period of zero, `wd_rst_req` rises on the first clock after the arming edge.
- R8: While armed, a 0xA5C6 write followed later by a 0xDA7E write clears the count to zero on the edge of the second write; the enable bit is not needed for these writes.
- R9: While armed, a write to 0x28 with any key other than 0xA5C6 or 0xDA7E raises `wd_rst_req` on that edge.
- R10: Once raised, `wd_rst_req` stays high until `rst_n` is asserted.
- R11: Before arming, the count halves (0x10 low, 0x14 high), the period halves (0x18 low, 0x1C high) and global control bits 3:0 at 0x24 read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address for write and read |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Combinational read data for `bus_addr` |
| wd_rst_req | output | 1 | Sticky system reset request |

## Verification
The bound checker watches on every cycle that the armed state and the reset request never fall back, that the period cannot change once armed, that the count steps by exactly one or clears while running and freezes after a request, and that a period match or a wrong key while armed is followed by a request on the next edge. Only the bench's scenarios show the ordering rules of the key sequence: the abort from the half-armed state, the mode gating of arming, service clearing at the right edge, and the zero-period corner, all compared cycle by cycle against a behavioural model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned KEY_LSB = 16;
  localparam int unsigned EN_BIT  = 14;

  localparam logic [7:0] A_CNT_LO = 8'h10;
  localparam logic [7:0] A_PRD_LO = 8'h18;
  localparam logic [7:0] A_GCTL   = 8'h24;
  localparam logic [7:0] A_WCTL   = 8'h28;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;

  localparam logic [1:0] MODE_WDOG = 2'd2;
  localparam int unsigned GCTL_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_ARMED = 2'd2
  } kwdt_state_e;
endpackage

// File: rtl/kwdt_key_fsm.sv
module kwdt_key_fsm
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  input  logic             mode_ok,
  output logic             armed,
  output logic             svc_clear,
  output logic             bad_key
);
  kwdt_state_e state_q, state_d;
  logic        pend_q, pend_d;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    svc_clear = 1'b0;
    bad_key   = 1'b0;
    if (ctl_wr) begin
      case (state_q)
        ST_IDLE: begin
          if (key == KEY_FIRST && en_bit && mode_ok) state_d = ST_PRE;
        end
        ST_PRE: begin
          if (key == KEY_SECOND && en_bit && mode_ok) state_d = ST_ARMED;
          else                                         state_d = ST_IDLE;
        end
        ST_ARMED: begin
          if (key == KEY_FIRST) begin
            pend_d = 1'b1;
          end else if (key == KEY_SECOND) begin
            if (pend_q) begin
              svc_clear = 1'b1;
              pend_d    = 1'b0;
            end
          end else begin
            bad_key = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        state_q <= state_d;
        pend_q  <= pend_d;
      end
    end
  end

  assign armed = (state_q == ST_ARMED);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned NHALF = CNT_W / BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [NHALF-1:0] ld_en,
  input  logic [BUS_W-1:0] ld_data,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      for (int i = 0; i < int'(NHALF); i++) begin
        if (ld_en[i]) cnt_d[i*BUS_W +: BUS_W] = ld_data;
      end
    end
  end

  assign cnt_en = clr | run | (|ld_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/kwdt_period.sv
module kwdt_period #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned NHALF = CNT_W / BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NHALF-1:0] ld_en,
  input  logic [BUS_W-1:0] ld_data,
  output logic [CNT_W-1:0] period
);
  for (genvar g = 0; g < int'(NHALF); g++) begin : g_half
    logic [BUS_W-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        half_q <= '0;
      else if (ld_en[g]) half_q <= ld_data;
    end
    assign period[g*BUS_W +: BUS_W] = half_q;
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              wd_rst_req
);
  localparam int unsigned NHALF  = CNT_W / BUS_W;
  localparam int unsigned STRIDE = BUS_W / 8;

  logic              armed, svc_clear, bad_key, mode_ok, run, hit;
  logic              ctl_wr, gctl_wr;
  logic [NHALF-1:0]  cnt_ld, prd_ld;
  logic [NHALF-1:0]  cnt_rd, prd_rd;
  logic [CNT_W-1:0]  count_w, period_w;
  logic [GCTL_W-1:0] gctl_q, gctl_d;
  logic              req_q, req_d;

  // address decode, one pair of strobes per counter half
  for (genvar g = 0; g < int'(NHALF); g++) begin : g_dec
    assign cnt_rd[g] = (bus_addr == ADDR_W'(int'(A_CNT_LO) + g*int'(STRIDE)));
    assign prd_rd[g] = (bus_addr == ADDR_W'(int'(A_PRD_LO) + g*int'(STRIDE)));
    assign cnt_ld[g] = bus_wr & ~armed & cnt_rd[g];
    assign prd_ld[g] = bus_wr & ~armed & prd_rd[g];
  end

  assign ctl_wr  = bus_wr & (bus_addr == ADDR_W'(A_WCTL));
  assign gctl_wr = bus_wr & ~armed & (bus_addr == ADDR_W'(A_GCTL));
  assign mode_ok = (gctl_q == {MODE_WDOG, 2'b11});

  kwdt_key_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .key       (bus_wdata[KEY_LSB +: KEY_W]),
    .en_bit    (bus_wdata[EN_BIT]),
    .mode_ok   (mode_ok),
    .armed     (armed),
    .svc_clear (svc_clear),
    .bad_key   (bad_key)
  );

  assign run = armed & ~req_q;

  kwdt_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .clr     (svc_clear),
    .ld_en   (cnt_ld),
    .ld_data (bus_wdata),
    .count   (count_w)
  );

  kwdt_period #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_prd (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (prd_ld),
    .ld_data (bus_wdata),
    .period  (period_w)
  );

  assign hit = run & (count_w == period_w);

  always_comb begin
    gctl_d = gctl_wr ? bus_wdata[GCTL_W-1:0] : gctl_q;
    req_d  = req_q | bad_key | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (gctl_wr) gctl_q <= gctl_d;
      req_q <= req_d;
    end
  end

  assign wd_rst_req = req_q;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < int'(NHALF); i++) begin
      if (cnt_rd[i]) bus_rdata = count_w[i*BUS_W +: BUS_W];
      if (prd_rd[i]) bus_rdata = period_w[i*BUS_W +: BUS_W];
    end
    if (bus_addr == ADDR_W'(A_GCTL)) bus_rdata = BUS_W'(gctl_q);
    if (bus_addr == ADDR_W'(A_WCTL)) bus_rdata = BUS_W'({armed, {EN_BIT{1'b0}}});
  end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              armed,
  input logic              wd_rst_req,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  period
);
  logic [KEY_W-1:0] key;
  logic             ctl_wr;
  assign key    = bus_wdata[KEY_LSB +: KEY_W];
  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(A_WCTL));

  a_r10_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> wd_rst_req);

  a_r5_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  a_r5_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(period));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wd_rst_req) |=> (count == $past(count) + CNT_W'(1)) || (count == '0));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_req && !ctl_wr) |=> $stable(count));

  a_r6_hit_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wd_rst_req && count == period) |=> wd_rst_req);

  a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ctl_wr && key != KEY_FIRST && key != KEY_SECOND) |=> wd_rst_req);
endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .armed      (armed),
  .wd_rst_req (wd_rst_req),
  .count      (count_w),
  .period     (period_w)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wd_rst_req;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  kwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst_req(wd_rst_req)
  );

  // behavioural reference: 0 idle, 1 first key seen, 2 armed
  int        m_st;
  bit        m_pend, m_req;
  bit [63:0] m_cnt, m_prd;
  bit [3:0]  m_gctl;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h10: return m_cnt[31:0];
      8'h14: return m_cnt[63:32];
      8'h18: return m_prd[31:0];
      8'h1C: return m_prd[63:32];
      8'h24: return {28'd0, m_gctl};
      8'h28: return (m_st == 2) ? 32'h0000_4000 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_req = 0; m_cnt = 0; m_prd = 0; m_gctl = 0;
    end else begin
      bit [15:0] k;
      bit        en, was_armed, hit, clr, bad;
      k = bus_wdata[31:16];
      en = bus_wdata[14];
      was_armed = (m_st == 2);
      hit = was_armed && !m_req && (m_cnt == m_prd);
      clr = 0; bad = 0;
      if (bus_wr && bus_addr == 8'h28) begin
        if (m_st == 0) begin
          if (k == 16'hA5C6 && en && m_gctl == 4'hB) m_st = 1;
        end else if (m_st == 1) begin
          m_st = (k == 16'hDA7E && en && m_gctl == 4'hB) ? 2 : 0;
        end else begin
          if (k == 16'hA5C6) m_pend = 1;
          else if (k == 16'hDA7E) begin
            if (m_pend) begin clr = 1; m_pend = 0; end
          end else bad = 1;
        end
      end
      if (clr) m_cnt = 0;
      else if (was_armed && !m_req) m_cnt = m_cnt + 1;
      else if (!was_armed && bus_wr) begin
        if (bus_addr == 8'h10) m_cnt[31:0]  = bus_wdata;
        if (bus_addr == 8'h14) m_cnt[63:32] = bus_wdata;
      end
      if (!was_armed && bus_wr) begin
        if (bus_addr == 8'h18) m_prd[31:0]  = bus_wdata;
        if (bus_addr == 8'h1C) m_prd[63:32] = bus_wdata;
        if (bus_addr == 8'h24) m_gctl = bus_wdata[3:0];
      end
      m_req = m_req | bad | hit;
    end
    chk(wd_rst_req, m_req, "R6/R9/R10 per-cycle request");
    chk(bus_rdata, m_read(bus_addr), "R6/R11 per-cycle read");
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic arm();
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h28, 32'hDA7E_4000);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h10, 0, "R1 count lo"); rd(8'h14, 0, "R1 count hi");
    rd(8'h18, 0, "R1 period lo"); rd(8'h1C, 0, "R1 period hi");
    rd(8'h24, 0, "R1 gctl"); rd(8'h28, 0, "R1 wctl");
    chk(wd_rst_req, 0, "R1 request");

    // R4 arming refused outside watchdog mode
    arm();
    rd(8'h28, 0, "R4 no arm, gctl=0");
    wr(8'h24, 32'h3);
    arm();
    rd(8'h28, 0, "R4 no arm, general mode");

    // R11 register read-back
    wr(8'h24, 32'hB);
    rd(8'h24, 32'hB, "R11 gctl");
    wr(8'h18, 32'd20); wr(8'h1C, 32'h0); wr(8'h10, 32'd3);
    rd(8'h10, 3, "R11 count lo");
    rd(8'h18, 20, "R11 period lo");

    // R2 arming, R6 counting
    arm();
    rd(8'h28, 32'h4000, "R2 armed");
    rd(8'h10, 3, "R2 count held at arming");
    repeat (5) @(negedge clk);
    rd(8'h10, 8, "R6 count after 5 clocks");

    // R5 sticky enable and locked registers
    wr(8'h28, 32'hA5C6_0000);
    rd(8'h28, 32'h4000, "R5 enable sticky");
    wr(8'h18, 32'd100);
    rd(8'h18, 20, "R5 period locked");
    wr(8'h24, 32'h0);
    rd(8'h24, 32'hB, "R5 gctl locked");

    // R8 service clears count
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, 0, "R8 service clear");

    // R6 timeout at count == period
    repeat (20) @(negedge clk);
    rd(8'h10, 20, "R6 count at period");
    chk(wd_rst_req, 0, "R6 no request yet");
    @(negedge clk);
    chk(wd_rst_req, 1, "R6 request on match");
    repeat (4) @(negedge clk);
    rd(8'h10, 21, "R6 count frozen");
    wr(8'h10, 32'h0);
    chk(wd_rst_req, 1, "R10 request sticky");

    do_reset();
    chk(wd_rst_req, 0, "R10 cleared by reset");
    rd(8'h28, 0, "R1 disarmed by reset");

    // R3 abort from first-key state
    wr(8'h24, 32'hB);
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h28, 32'h1234_4000);
    wr(8'h28, 32'hDA7E_4000);
    rd(8'h28, 0, "R3 abort returns to start");

    // R7 zero period
    arm();
    chk(wd_rst_req, 0, "R7 no request at arming");
    @(negedge clk);
    chk(wd_rst_req, 1, "R7 request next clock");

    // R9 bad key
    do_reset();
    wr(8'h24, 32'hB);
    wr(8'h18, 32'd1000);
    arm();
    repeat (3) @(negedge clk);
    wr(8'h28, 32'h0BAD_4000);
    chk(wd_rst_req, 1, "R9 bad key request");
    repeat (2) @(negedge clk);
    rd(8'h10, 5, "R9 count frozen");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule